// File: doc/BRIEF.md
# Slack-Leg Reference Re-Centring Unit

Two H-bridges that share one DC bus have four half-bridge legs. Only three leg currents are independent, so only three current controllers drive this unit. The unit takes their three signed voltage references and builds the fourth leg reference. That reference starts from zero and is the slack variable of the set. The unit then adds one common offset to all four references. A shift that is common to every leg leaves the leg currents unchanged, and it moves the set back towards the middle of the carrier range, away from modulator clipping.

The offset is chosen in one of two ways. In the default mode the largest and the smallest reference become equal in magnitude, which keeps narrow pulses and clipping least likely. In the other mode the four references add up to zero. All values are signed fixed point with one integer bit, in two's complement, and full scale maps to the carrier peak. The internal arithmetic has two guard bits, and every output saturates at the format limits.

A result is registered one clock after a qualified input and is marked by a single-cycle valid strobe.

Top module: `leg_offset_calc`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first qualified input, `out_valid` is 0 and all four outputs are 0.
- R2: `out_valid` is 1 in exactly the cycle after each cycle with `in_valid` high, and 0 otherwise. Back-to-back inputs give back-to-back results.
- R3: When `in_valid` is low, all four outputs hold their last values, whatever `ref_*` and `mode_sumzero` do.
- R4: Each output equals its source plus one common offset. The sources are `ref_a1`, `ref_b1` and `ref_b2`, and zero for the slack output `out_a2`. When no output saturates, every difference between two legs is kept exactly.
- R5: With `mode_sumzero` = 0 (balance mode, the default choice), offset = −floor((max + min) / 2), where max and min are taken over the set {ref_a1, ref_b1, 0, ref_b2}.
- R6: With `mode_sumzero` = 1 (zero-sum mode), offset = −floor((ref_a1 + ref_b1 + ref_b2) / 4).
- R7: Each output is clamped to [−2^(W−1), 2^(W−1)−1]. For W=16 that is [−32768, 32767].
- R8: `mode_sumzero` is taken only in a cycle with `in_valid` high. A change of mode while the unit is idle does not touch the held outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the three references and the mode |
| mode_sumzero | input | 1 | 0 = balance min/max, 1 = zero-sum offset |
| ref_a1 | input | W | Controller reference, leg A of bridge 1 |
| ref_b1 | input | W | Controller reference, leg B of bridge 1 |
| ref_b2 | input | W | Controller reference, leg B of bridge 2 |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_a1 | output | W | Re-centred reference, leg A of bridge 1 |
| out_b1 | output | W | Re-centred reference, leg B of bridge 1 |
| out_a2 | output | W | Slack-leg reference, leg A of bridge 2 |
| out_b2 | output | W | Re-centred reference, leg B of bridge 2 |

## Verification
The bench builds the unit twice. The first build uses W=4, which is small enough to apply every one of the 4096 input triplets in both modes. That sweep reaches every floor-rounding case, every ordering of max and min, and every saturation on either rail. The second build uses the default W=16 and runs a grid of values placed at the rails, near zero and at a few mid values, so the guard-bit sums are exercised at their true width. Directed sequences cover back-to-back inputs, holding while idle and mode changes between inputs.

// File: rtl/leg_offset_calc.sv
module leg_offset_calc #(
  parameter int W = 16,
  parameter int G = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                mode_sumzero,
  input  logic signed [W-1:0] ref_a1,
  input  logic signed [W-1:0] ref_b1,
  input  logic signed [W-1:0] ref_b2,
  output logic                out_valid,
  output logic signed [W-1:0] out_a1,
  output logic signed [W-1:0] out_b1,
  output logic signed [W-1:0] out_a2,
  output logic signed [W-1:0] out_b2
);
  localparam int XW = W + G;
  localparam logic signed [XW-1:0] XPOS = {{(G+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [XW-1:0] XNEG = {{(G+1){1'b1}}, {(W-1){1'b0}}};
  localparam logic signed [W-1:0]  OPOS = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0]  ONEG = {1'b1, {(W-1){1'b0}}};

  function automatic logic signed [XW-1:0] smax(input logic signed [XW-1:0] p, input logic signed [XW-1:0] q);
    return (p > q) ? p : q;
  endfunction

  function automatic logic signed [XW-1:0] smin(input logic signed [XW-1:0] p, input logic signed [XW-1:0] q);
    return (p < q) ? p : q;
  endfunction

  function automatic logic signed [W-1:0] clamp(input logic signed [XW-1:0] v);
    if (v > XPOS) return OPOS;
    if (v < XNEG) return ONEG;
    return v[W-1:0];
  endfunction

  logic signed [XW-1:0] xa1, xb1, xb2, zero, hi, lo, off;
  logic mode_q;

  assign xa1  = {{G{ref_a1[W-1]}}, ref_a1};
  assign xb1  = {{G{ref_b1[W-1]}}, ref_b1};
  assign xb2  = {{G{ref_b2[W-1]}}, ref_b2};
  assign zero = '0;
  assign hi   = smax(smax(xa1, xb1), smax(xb2, zero));
  assign lo   = smin(smin(xa1, xb1), smin(xb2, zero));
  assign off  = mode_sumzero ? -((xa1 + xb1 + xb2) >>> 2) : -((hi + lo) >>> 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mode_q    <= 1'b0;
      out_a1    <= '0;
      out_b1    <= '0;
      out_a2    <= '0;
      out_b2    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        mode_q <= mode_sumzero;
        out_a1 <= clamp(xa1 + off);
        out_b1 <= clamp(xb1 + off);
        out_a2 <= clamp(off);
        out_b2 <= clamp(xb2 + off);
      end
    end
  end

  logic signed [XW-1:0] ea1, eb1, ea2, eb2, ohi, olo, osum;
  logic at_rail;
  assign ea1  = {{G{out_a1[W-1]}}, out_a1};
  assign eb1  = {{G{out_b1[W-1]}}, out_b1};
  assign ea2  = {{G{out_a2[W-1]}}, out_a2};
  assign eb2  = {{G{out_b2[W-1]}}, out_b2};
  assign ohi  = smax(smax(ea1, eb1), smax(ea2, eb2));
  assign olo  = smin(smin(ea1, eb1), smin(ea2, eb2));
  assign osum = ea1 + eb1 + ea2 + eb2;
  assign at_rail = (out_a1 == OPOS) || (out_a1 == ONEG) || (out_b1 == OPOS) || (out_b1 == ONEG) ||
                   (out_a2 == OPOS) || (out_a2 == ONEG) || (out_b2 == OPOS) || (out_b2 == ONEG);

  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (out_valid == $past(in_valid)));

  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> ($stable(out_a1) && $stable(out_b1) && $stable(out_a2) && $stable(out_b2)));

  a_r4_diff_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && !at_rail) |->
      ((ea1 - eb1) == $past(xa1 - xb1) && (eb2 - ea2) == $past(xb2) && (ea1 - ea2) == $past(xa1)));

  a_r5_balanced: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && !mode_q && !at_rail) |-> ((ohi + olo) == 0 || (ohi + olo) == 1));

  a_r6_sum_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && out_valid && mode_q && !at_rail) |-> (osum >= 0 && osum <= 3));

  a_r8_mode_latched: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(in_valid)) |-> $stable(mode_q));
endmodule

// File: tb/leg_offset_calc_tb_top.sv
module leg_offset_calc_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  logic s_iv = 0, s_m = 0;
  logic signed [3:0] s_a1 = 0, s_b1 = 0, s_b2 = 0;
  logic s_ov;
  logic signed [3:0] s_oa1, s_ob1, s_oa2, s_ob2;

  logic b_iv = 0, b_m = 0;
  logic signed [15:0] b_a1 = 0, b_b1 = 0, b_b2 = 0;
  logic b_ov;
  logic signed [15:0] b_oa1, b_ob1, b_oa2, b_ob2;

  leg_offset_calc #(.W(4), .G(2)) dut_s (
    .clk(clk), .rst_n(rst_n), .in_valid(s_iv), .mode_sumzero(s_m),
    .ref_a1(s_a1), .ref_b1(s_b1), .ref_b2(s_b2), .out_valid(s_ov),
    .out_a1(s_oa1), .out_b1(s_ob1), .out_a2(s_oa2), .out_b2(s_ob2));

  leg_offset_calc dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(b_iv), .mode_sumzero(b_m),
    .ref_a1(b_a1), .ref_b1(b_b1), .ref_b2(b_b2), .out_valid(b_ov),
    .out_a1(b_oa1), .out_b1(b_ob1), .out_a2(b_oa2), .out_b2(b_ob2));

  // expected values from R4..R7; order a1, b1, a2 (slack), b2
  function automatic void model(input int a, input int b, input int c, input bit m, input int w,
                                output int e1, output int e2, output int e3, output int e4, output bit sat);
    int hi, lo, off, pos, neg;
    int raw [4];
    int e [4];
    hi = (a > b) ? a : b;   hi = (c > hi) ? c : hi;   hi = (hi < 0) ? 0 : hi;
    lo = (a < b) ? a : b;   lo = (c < lo) ? c : lo;   lo = (lo > 0) ? 0 : lo;
    off = m ? -((a + b + c) >>> 2) : -((hi + lo) >>> 1);
    pos = (1 <<< (w - 1)) - 1;
    neg = -(1 <<< (w - 1));
    raw = '{a + off, b + off, off, c + off};
    sat = 1'b0;
    for (int k = 0; k < 4; k++) begin
      e[k] = raw[k];
      if (raw[k] > pos) begin e[k] = pos; sat = 1'b1; end
      if (raw[k] < neg) begin e[k] = neg; sat = 1'b1; end
    end
    e1 = e[0]; e2 = e[1]; e3 = e[2]; e4 = e[3];
  endfunction

  task automatic check4(input string tag, input bit vg, input bit ve,
                        input int g1, input int g2, input int g3, input int g4,
                        input int x1, input int x2, input int x3, input int x4);
    n_chk++;
    if (vg !== ve || g1 != x1 || g2 != x2 || g3 != x3 || g4 != x4) begin
      n_bad++;
      $display("FAIL %s actual v=%0b %0d %0d %0d %0d expected v=%0b %0d %0d %0d %0d",
               tag, vg, g1, g2, g3, g4, ve, x1, x2, x3, x4);
    end
  endtask

  task automatic run_s(input int a, input int b, input int c, input bit m);
    int e1, e2, e3, e4;
    bit sat;
    model(a, b, c, m, 4, e1, e2, e3, e4, sat);
    @(negedge clk);
    s_a1 = 4'(a); s_b1 = 4'(b); s_b2 = 4'(c); s_m = m; s_iv = 1'b1;
    @(negedge clk);
    s_iv = 1'b0;
    check4(sat ? "R7 sat W4" : (m ? "R6 sumzero W4" : "R5 minmax W4"), s_ov, 1'b1,
           int'(s_oa1), int'(s_ob1), int'(s_oa2), int'(s_ob2), e1, e2, e3, e4);
  endtask

  task automatic run_b(input int a, input int b, input int c, input bit m);
    int e1, e2, e3, e4;
    bit sat;
    model(a, b, c, m, 16, e1, e2, e3, e4, sat);
    @(negedge clk);
    b_a1 = 16'(a); b_b1 = 16'(b); b_b2 = 16'(c); b_m = m; b_iv = 1'b1;
    @(negedge clk);
    b_iv = 1'b0;
    check4(sat ? "R7 sat W16" : (m ? "R6 sumzero W16" : "R5 minmax W16"), b_ov, 1'b1,
           int'(b_oa1), int'(b_ob1), int'(b_oa2), int'(b_ob2), e1, e2, e3, e4);
  endtask

  task automatic finish_run;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog R2 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int vals [8] = '{-32768, -20001, -3, -1, 0, 1, 9999, 32767};
    int e1, e2, e3, e4;
    bit sat;

    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check4("R1 in reset W16", b_ov, 1'b0, int'(b_oa1), int'(b_ob1), int'(b_oa2), int'(b_ob2), 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R1: outputs after release, before any input
    check4("R1 after release W16", b_ov, 1'b0, int'(b_oa1), int'(b_ob1), int'(b_oa2), int'(b_ob2), 0, 0, 0, 0);
    check4("R1 after release W4", s_ov, 1'b0, int'(s_oa1), int'(s_ob1), int'(s_oa2), int'(s_ob2), 0, 0, 0, 0);

    // R4 R5 R6 R7: exhaustive sweep of the small build
    for (int m = 0; m < 2; m++)
      for (int a = -8; a < 8; a++)
        for (int b = -8; b < 8; b++)
          for (int c = -8; c < 8; c++)
            run_s(a, b, c, m[0]);

    // R4 R5 R6 R7: grid sweep of the default build
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 8; k++)
            run_b(vals[i], vals[j], vals[k], m[0]);

    // R2: strobe drops after a single input
    @(negedge clk);
    check4("R2 strobe low", b_ov, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);

    // R2: back-to-back inputs give back-to-back results
    @(negedge clk);
    b_a1 = 16'sd1000; b_b1 = -16'sd200; b_b2 = 16'sd300; b_m = 1'b0; b_iv = 1'b1;
    @(negedge clk);
    model(1000, -200, 300, 1'b0, 16, e1, e2, e3, e4, sat);
    check4("R2 first of pair", b_ov, 1'b1, int'(b_oa1), int'(b_ob1), int'(b_oa2), int'(b_ob2), e1, e2, e3, e4);
    b_a1 = -16'sd5000; b_b1 = 16'sd7; b_b2 = 16'sd1234; b_m = 1'b1;
    @(negedge clk);
    b_iv = 1'b0;
    model(-5000, 7, 1234, 1'b1, 16, e1, e2, e3, e4, sat);
    check4("R2 second of pair", b_ov, 1'b1, int'(b_oa1), int'(b_ob1), int'(b_oa2), int'(b_ob2), e1, e2, e3, e4);

    // R3 R8: inputs and mode change while idle; outputs hold
    b_a1 = 16'sd32000; b_b1 = -16'sd32000; b_b2 = 16'sd1; b_m = 1'b0;
    repeat (2) @(negedge clk);
    b_m = 1'b1;
    repeat (2) @(negedge clk);
    check4("R3 R8 hold while idle", b_ov, 1'b0, int'(b_oa1), int'(b_ob1), int'(b_oa2), int'(b_ob2), e1, e2, e3, e4);

    // R8: mode in force at the qualified input is the one applied
    run_b(32000, -32000, 1, 1'b0);

    finish_run();
  end
endmodule